// File: doc/BRIEF.md
# Radix-Matched Code Predistorter

This block rewrites a digital code for a serial two-capacitor DAC whose two capacitors are not exactly equal. Such a DAC weights its input bits by powers of an effective radix that differs slightly from two. The block searches, one bit per clock, for the code whose weighted sum under the real radix comes closest to the requested value. It works like a successive-approximation search, but against powers of a programmed reciprocal radix instead of powers of one half.

A conversion begins when `start` is seen while the engine is idle. At that point the block latches the signed input and the reciprocal radix. It scales the input by the reciprocal radix; a negative input is clamped to zero. It then makes M decisions, where M is N, or N+1 when the extra-bit option is set. At step i the residual is compared with w^i, where w is the reciprocal radix. If the residual is not smaller, the bit is 1 and w^i is subtracted. Each next power is formed by multiplying by w and truncating to FW fraction bits. `done` pulses for one cycle when the code is complete. The code is then held until the next accepted start.

Top module: `radix_predist`

## Requirements
- R1: After reset `busy`, `done` and `code` are all zero.
- R2: When `start` is sampled high while idle, `done` rises exactly M clock edges later (M = N + EXTRA), stays high for one cycle, and `busy` is low while `done` is high.
- R3: With the reciprocal radix equal to exactly one half (bit FW-1 set, all other bits zero) and EXTRA = 0, `code` equals bits N-1..0 of a non-negative `din`.
- R4: For any reciprocal radix w (unsigned, FW fraction bits), the code matches the greedy search. The initial residual is floor(din_mag * w / 2^(N-1)) with FW fraction bits, and the first power is w. Each step sets the bit when residual >= power, then subtracts. The next power is floor(power * w / 2^FW).
- R5: The first decision is written to the most significant code bit (index M-1), and later decisions go to successively lower bits.
- R6: A negative `din` (bit N set) yields an all-zero code.
- R7: An input whose scaled value exceeds the sum of all M powers yields an all-ones code.
- R8: With EXTRA = 1 the code has N+1 bits, `done` comes N+1 edges after start, and at a reciprocal radix of one half the code equals `din` shifted left by one.
- R9: `start` while a conversion is running is ignored: the running result and its `done` timing are unchanged.
- R10: While idle with `start` low, `code` stays unchanged whatever `din` and `recip_radix` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion when idle |
| din | input | N+1 | Signed input, value din/2^(N-1) |
| recip_radix | input | FW | Reciprocal of the radix, unsigned fraction |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the code is complete |
| code | output | N+EXTRA | Predistorted code, first decision at the top bit |

## Verification
The hardest case to reach from the ports is saturation. It needs a scaled input larger than the sum of all truncated powers, and that happens only when the reciprocal radix is below one half. The bench programs a reciprocal radix of about 0.45 with an input near full scale, so every comparison succeeds. It also pulses `start` in the middle of a run, to show that the search is not restarted.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic {RP_IDLE, RP_RUN} rp_state_e;
endpackage

// File: rtl/rp_scale.sv
module rp_scale #(
  parameter int N  = 8,
  parameter int FW = 16
) (
  input  logic [N:0]    din,
  input  logic [FW-1:0] w,
  output logic [FW:0]   scaled
);
  // magnitude (format 1.(N-1)) times w (format 0.FW), rescaled to FW fraction bits
  function automatic logic [FW:0] scale_frac(input logic [N-1:0] mag, input logic [FW-1:0] rw);
    return (FW+1)'(({{FW{1'b0}}, mag} * {{N{1'b0}}, rw}) >> (N-1));
  endfunction

  assign scaled = din[N] ? '0 : scale_frac(din[N-1:0], w);
endmodule

// File: rtl/rp_decide.sv
module rp_decide #(
  parameter int FW = 16
) (
  input  logic [FW:0]   rem,
  input  logic [FW-1:0] pow,
  input  logic [FW-1:0] w,
  output logic          bit_one,
  output logic [FW:0]   rem_nxt,
  output logic [FW-1:0] pow_nxt
);
  function automatic logic [FW-1:0] frac_mul(input logic [FW-1:0] a, input logic [FW-1:0] b);
    return FW'(({{FW{1'b0}}, a} * {{FW{1'b0}}, b}) >> FW);
  endfunction

  assign bit_one = rem >= {1'b0, pow};
  assign rem_nxt = bit_one ? rem - {1'b0, pow} : rem;
  assign pow_nxt = frac_mul(pow, w);
endmodule

// File: rtl/rp_ctrl.sv
module rp_ctrl import rp_pkg::*; #(
  parameter int M  = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          load,
  output logic          step,
  output logic [IW-1:0] step_idx,
  output logic          busy,
  output logic          done
);
  rp_state_e state;

  assign step = (state == RP_RUN);
  assign busy = step;
  assign load = start && (state == RP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RP_IDLE;
      step_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        RP_IDLE: if (start) begin
          state    <= RP_RUN;
          step_idx <= '0;
        end
        default: if (step_idx == IW'(M-1)) begin
          state <= RP_IDLE;
          done  <= 1'b1;
        end else begin
          step_idx <= step_idx + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/radix_predist.sv
module radix_predist #(
  parameter int N     = 8,
  parameter int FW    = N + 8,
  parameter int EXTRA = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N:0]           din,
  input  logic [FW-1:0]        recip_radix,
  output logic                 busy,
  output logic                 done,
  output logic [N+EXTRA-1:0]   code
);
  localparam int M  = N + EXTRA;
  localparam int IW = $clog2(M + 1);

  logic          load, step, bit_one;
  logic [IW-1:0] step_idx, bit_pos;
  logic [FW:0]   scaled, rem_q, rem_nxt;
  logic [FW-1:0] pow_q, pow_nxt, w_q;

  rp_scale #(.N(N), .FW(FW)) u_scale (
    .din(din), .w(recip_radix), .scaled(scaled)
  );

  rp_ctrl #(.M(M), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load), .step(step),
    .step_idx(step_idx), .busy(busy), .done(done)
  );

  rp_decide #(.FW(FW)) u_dec (
    .rem(rem_q), .pow(pow_q), .w(w_q),
    .bit_one(bit_one), .rem_nxt(rem_nxt), .pow_nxt(pow_nxt)
  );

  // first decision lands on the top bit, the one the serial DAC takes last
  assign bit_pos = IW'(M-1) - step_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      pow_q <= '0;
      w_q   <= '0;
      code  <= '0;
    end else if (load) begin
      rem_q <= scaled;
      pow_q <= recip_radix;
      w_q   <= recip_radix;
      code  <= '0;
    end else if (step) begin
      rem_q <= rem_nxt;
      pow_q <= pow_nxt;
      for (int k = 0; k < M; k++) begin
        if (bit_pos == IW'(k)) code[k] <= bit_one;
      end
    end
  end
endmodule

// File: rtl/rp_checker.sv
module rp_checker #(
  parameter int N     = 8,
  parameter int FW    = N + 8,
  parameter int EXTRA = 0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 din_neg,
  input logic                 busy,
  input logic                 done,
  input logic [N+EXTRA-1:0]   code,
  input logic [FW:0]          rem_q,
  input logic [$clog2(N+EXTRA+1)-1:0] step_idx
);
  localparam int M  = N + EXTRA;
  localparam int IW = $clog2(M + 1);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_rem_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> rem_q <= $past(rem_q));

  p_neg_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && din_neg) |=> (rem_q == '0));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_idx != IW'(M-1)) |=> (busy && step_idx == IW'($past(step_idx) + 1'b1)));

  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(code));
endmodule

bind radix_predist rp_checker #(.N(N), .FW(FW), .EXTRA(EXTRA)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .din_neg(din[N]), .busy(busy),
  .done(done), .code(code), .rem_q(rem_q), .step_idx(step_idx)
);

// File: tb/tb_radix_predist.sv
`timescale 1ns/1ps
module tb_radix_predist;
  localparam int N  = 8;
  localparam int FW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N:0] din = '0;
  logic [FW-1:0] w = '0;
  logic busy0, done0, busy1, done1;
  logic [N-1:0] code0;
  logic [N:0]   code1;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  radix_predist #(.N(N), .FW(FW), .EXTRA(0)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din), .recip_radix(w),
    .busy(busy0), .done(done0), .code(code0));

  radix_predist #(.N(N), .FW(FW), .EXTRA(1)) dut_x (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din), .recip_radix(w),
    .busy(busy1), .done(done1), .code(code1));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // greedy search restated with integer arithmetic
  function automatic longint model(input logic [N:0] d, input longint rw, input int m);
    longint r, p, c;
    if (d[N]) return 0;
    r = (longint'(d[N-1:0]) * rw) / (longint'(1) << (N-1));
    p = rw; c = 0;
    for (int i = 0; i < m; i++) begin
      if (r >= p) begin
        c = c | (longint'(1) << (m-1-i));
        r = r - p;
      end
      p = (p * rw) / (longint'(1) << FW);
    end
    return c;
  endfunction

  // runs one conversion; checks latency of both instances, returns codes
  task automatic convert(input logic [N:0] d, input logic [FW-1:0] rw, input int mid_start,
                         output longint c0, output longint c1);
    int first0 = -1, first1 = -1, cnt0 = 0;
    @(negedge clk); din = d; w = rw; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 1; c <= 14; c++) begin
      if (mid_start != 0 && c == mid_start) begin
        din = 9'h033; w = 16'h7000; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (done0) begin cnt0++; if (first0 < 0) begin first0 = c; c0 = code0; end end
      if (done1 && first1 < 0) begin first1 = c; c1 = code1; end
    end
    chk(first0 == N && cnt0 == 1, "R2 done timing", first0, N);
    chk(first1 == N+1, "R8 done timing", first1, N+1);
    if (first0 < 0) c0 = -1;
    if (first1 < 0) c1 = -1;
  endtask

  task automatic t_reset;
    chk(busy0 == 0 && done0 == 0 && code0 == 0, "R1 reset", code0, 0);
  endtask

  task automatic t_ideal;
    longint c0, c1;
    logic [N:0] vals [3] = '{9'h0B5, 9'h001, 9'h0FF};
    foreach (vals[k]) begin
      convert(vals[k], 16'h8000, 0, c0, c1);
      chk(c0 == vals[k][N-1:0], "R3 ideal radix", c0, vals[k][N-1:0]);
      chk(c1 == longint'(vals[k][N-1:0]) * 2, "R8 extra bit ideal", c1, longint'(vals[k][N-1:0]) * 2);
    end
  endtask

  task automatic t_general;
    longint c0, c1;
    convert(9'h0C8, 16'd31457, 0, c0, c1);
    chk(c0 == model(9'h0C8, 31457, N), "R4 radix 0.48", c0, model(9'h0C8, 31457, N));
    chk(c1 == model(9'h0C8, 31457, N+1), "R8 radix 0.48", c1, model(9'h0C8, 31457, N+1));
    convert(9'h064, 16'd34079, 0, c0, c1);
    chk(c0 == model(9'h064, 34079, N), "R4 radix 0.52 a", c0, model(9'h064, 34079, N));
    convert(9'h025, 16'd34079, 0, c0, c1);
    chk(c0 == model(9'h025, 34079, N), "R4 radix 0.52 b", c0, model(9'h025, 34079, N));
  endtask

  task automatic t_order;
    longint c0, c1;
    convert(9'h080, 16'd39322, 0, c0, c1);
    chk(c0 == 128, "R5 first decision at top bit", c0, 128);
    chk(c1 == 256, "R5 top bit extra", c1, 256);
  endtask

  task automatic t_negative;
    longint c0, c1;
    convert(9'h1CE, 16'h8000, 0, c0, c1);
    chk(c0 == 0, "R6 negative clamp", c0, 0);
    chk(c1 == 0, "R6 negative clamp extra", c1, 0);
  endtask

  task automatic t_saturate;
    longint c0, c1;
    convert(9'h0FA, 16'd29491, 0, c0, c1);
    chk(c0 == 255, "R7 saturation", c0, 255);
    chk(c1 == 511, "R7 saturation extra", c1, 511);
  endtask

  task automatic t_busy_start;
    longint c0, c1;
    convert(9'h0C8, 16'd31457, 3, c0, c1);
    chk(c0 == model(9'h0C8, 31457, N), "R9 start ignored while busy", c0, model(9'h0C8, 31457, N));
  endtask

  task automatic t_hold;
    longint c0, c1;
    logic [N-1:0] keep;
    convert(9'h05A, 16'h8000, 0, c0, c1);
    keep = code0;
    @(negedge clk); din = 9'h0FF; w = 16'd30000;
    repeat (6) @(negedge clk);
    chk(code0 == keep && !busy0, "R10 code held while idle", code0, keep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ideal();
    t_general();
    t_order();
    t_negative();
    t_saturate();
    t_busy_start();
    t_hold();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule